// File: doc/BRIEF.md
# Serial Status Flag Controller

This block holds the eight status flags of a UART-style serial port and packs them into one status byte for the bus. Single-cycle event pulses arrive from the transmitter and receiver cores. One pulse means the transmit holding register has been emptied. Another means the shift-out has finished. The rest cover a received character, a line gone idle, and overrun, noise, framing and parity errors. Each pulse sets its flag on the next clock edge.

Software clears a flag with a two-step handshake. It first reads the status register while the flag is 1, which arms that flag. A later data-register access of the right kind then clears it. A data write clears the two transmit-side flags. A data read clears the six receive-side flags. Only flags armed by an earlier status read are cleared. Any flag that rose after that read survives the access.

The idle flag has two extra rules. Once cleared, it cannot rise again until the receiver reports line activity. It also cannot rise while the receiver is in wake-up mode.

Top module: `sflag_unit`

## Requirements
- R1: After reset the status byte reads 0xC0: both transmit flags set, all other flags clear.
- R2: The status byte holds, from bit 7 down to bit 0: transmit-empty, transmit-done, receive-full, line-idle, overrun, noise, framing error, parity error. `evSet` uses the same bit positions. A 1 on an `evSet` bit sets that status bit on the next clock edge.
- R3: Bits 7 and 6 clear on the edge of a data write, but only if a status read in an earlier cycle saw them at 1. A data read leaves them unchanged.
- R4: Bits 5 down to 0 clear on the edge of a data read, but only if a status read in an earlier cycle saw them at 1. A data write leaves them unchanged.
- R5: A data access with no armed flag changes no status bit.
- R6: A flag that rose after the last status read is not cleared by the following data access, while armed flags in the same group are cleared.
- R7: If a set pulse and a clearing access hit the same flag in the same cycle, the flag stays 1.
- R8: Once the line-idle flag (bit 4) has been cleared, later idle pulses are ignored until an `rxActive` pulse has been seen.
- R9: While `rxWake` is 1, idle pulses do not set bit 4. A pulse ignored this way does not use up the permission granted by `rxActive`.
- R10: A data access uses up the arming of the flags it clears. A second access of the same kind needs a new status read before it clears anything.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| evSet | input | 8 | Per-flag set pulses, same bit positions as `statusByte` |
| rxActive | input | 1 | Pulse: receive line seen active; re-enables idle detection |
| rxWake | input | 1 | Receiver wake-up mode; blocks setting of the idle flag |
| statusRd | input | 1 | Bus read strobe for the status register |
| dataRd | input | 1 | Bus read strobe for the data register |
| dataWr | input | 1 | Bus write strobe for the data register |
| statusByte | output | 8 | Packed status flags |

## Verification
Each result is due one clock edge after its cause, with the status byte taken straight from the flag registers. A set pulse, a clearing data access, and a status read that arms flags all take effect on the next rising edge. The bench drives every strobe for exactly one cycle, starting just after a falling edge. It samples `statusByte` at the following falling edge, half a period after the edge that acted. This way every check lands one register delay after its stimulus. Arming needs the status read and the data access in separate cycles, and the bench spaces them one cycle apart, the shortest legal gap.

// File: rtl/sflag_pkg.sv
package sflag_pkg;
  localparam int FLAG_W   = 8;
  localparam int TX_CNT   = 2;
  localparam int IDLE_BIT = 4;
  localparam logic [FLAG_W-1:0] RESET_FLAGS = {{TX_CNT{1'b1}}, {(FLAG_W-TX_CNT){1'b0}}};

  // Strobes passed from control to datapath.
  typedef struct packed {
    logic [FLAG_W-1:0] clr;
    logic              txAck;
    logic              rxAck;
  } ackStrobes_t;
endpackage

// File: rtl/sflag_ctrl.sv
module sflag_ctrl
  import sflag_pkg::*;
#(
  parameter int W  = FLAG_W,
  parameter int TX = TX_CNT
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         statusRd,
  input  logic         dataRd,
  input  logic         dataWr,
  input  logic [W-1:0] flags,
  output ackStrobes_t  ack
);
  localparam logic [W-1:0] TX_MASK = {{TX{1'b1}}, {(W-TX){1'b0}}};

  logic [W-1:0] armed;
  logic [W-1:0] accessMask;
  logic [W-1:0] armedNext;

  always_comb begin
    accessMask = (dataWr ? TX_MASK : '0) | (dataRd ? ~TX_MASK : '0);
    ack.clr    = armed & accessMask;
    ack.txAck  = dataWr;
    ack.rxAck  = dataRd;
    armedNext  = (armed & ~accessMask) | (statusRd ? (flags & ~ack.clr) : '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) armed <= '0;
    else       armed <= armedNext;
  end

  // R6
  armed_tracks_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (armed & ~flags) == '0);

  // R10
  arm_consumed_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dataRd && !statusRd) |=> (armed & ~TX_MASK) == '0);
endmodule

// File: rtl/sflag_dp.sv
module sflag_dp
  import sflag_pkg::*;
#(
  parameter int W    = FLAG_W,
  parameter int IDLE = IDLE_BIT,
  parameter logic [W-1:0] RST = RESET_FLAGS
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] evSet,
  input  logic         rxActive,
  input  logic         rxWake,
  input  ackStrobes_t  ack,
  output logic [W-1:0] flags
);
  logic         idleEnable;
  logic [W-1:0] setEff;

  for (genvar i = 0; i < W; i++) begin : g_flag
    if (i == IDLE) begin : g_idle
      always_comb setEff[i] = evSet[i] && idleEnable && !rxWake;
    end else begin : g_plain
      always_comb setEff[i] = evSet[i];
      // R7
      set_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
        evSet[i] |=> flags[i]);
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) flags[i] <= RST[i];
      else       flags[i] <= setEff[i] | (flags[i] & ~ack.clr[i]);
    end

    // R5
    fall_needs_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
      $fell(flags[i]) |-> $past(ack.clr[i]));
  end

  // Idle re-arm: cleared when the idle flag is actually acknowledged away,
  // restored by observed line activity.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                              idleEnable <= 1'b1;
    else if (rxActive)                      idleEnable <= 1'b1;
    else if (ack.clr[IDLE] && !setEff[IDLE]) idleEnable <= 1'b0;
  end

  // R8
  idle_rearm_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!flags[IDLE] && !idleEnable) |=> !flags[IDLE]);

  // R9
  idle_wake_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxWake && !flags[IDLE]) |=> !flags[IDLE]);
endmodule

// File: rtl/sflag_unit.sv
module sflag_unit
  import sflag_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [FLAG_W-1:0] evSet,
  input  logic              rxActive,
  input  logic              rxWake,
  input  logic              statusRd,
  input  logic              dataRd,
  input  logic              dataWr,
  output logic [FLAG_W-1:0] statusByte
);
  ackStrobes_t       ack;
  logic [FLAG_W-1:0] flags;

  sflag_ctrl #(.W(FLAG_W), .TX(TX_CNT)) u_ctrl (
    .clk(clk), .rstN(rstN), .statusRd(statusRd), .dataRd(dataRd),
    .dataWr(dataWr), .flags(flags), .ack(ack)
  );

  sflag_dp #(.W(FLAG_W), .IDLE(IDLE_BIT), .RST(RESET_FLAGS)) u_dp (
    .clk(clk), .rstN(rstN), .evSet(evSet), .rxActive(rxActive),
    .rxWake(rxWake), .ack(ack), .flags(flags)
  );

  assign statusByte = flags;

  // R1
  reset_value_chk: assert property (@(posedge clk)
    $rose(rstN) |-> statusByte == RESET_FLAGS);
endmodule

// File: tb/sflag_unit_tb.sv
module sflag_unit_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] evSet = '0;
  logic       rxActive = 1'b0, rxWake = 1'b0;
  logic       statusRd = 1'b0, dataRd = 1'b0, dataWr = 1'b0;
  logic [7:0] statusByte;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  sflag_unit u_dut (
    .clk(clk), .rstN(rstN), .evSet(evSet), .rxActive(rxActive),
    .rxWake(rxWake), .statusRd(statusRd), .dataRd(dataRd),
    .dataWr(dataWr), .statusByte(statusByte)
  );

  task automatic check(input string tag, input logic [7:0] exp);
    checks++;
    if (statusByte !== exp) begin
      errors++;
      $display("FAIL %s: status actual=%02h expected=%02h", tag, statusByte, exp);
    end
  endtask

  // each helper drives a one-cycle strobe after a falling edge and returns
  // at the next falling edge, after the acting rising edge
  task automatic pulseEv(input logic [7:0] m);
    evSet = m; @(negedge clk); evSet = '0;
  endtask
  task automatic rdStatus(); statusRd = 1'b1; @(negedge clk); statusRd = 1'b0; endtask
  task automatic rdData();   dataRd = 1'b1;   @(negedge clk); dataRd = 1'b0;   endtask
  task automatic wrData();   dataWr = 1'b1;   @(negedge clk); dataWr = 1'b0;   endtask
  task automatic active();   rxActive = 1'b1; @(negedge clk); rxActive = 1'b0; endtask

  task automatic t_reset();
    check("R1 reset value", 8'hC0);
  endtask

  task automatic t_rxGroup();
    pulseEv(8'h28);           check("R2 receive-full and overrun set", 8'hE8);
    rdData();                 check("R5 data read without status read", 8'hE8);
    rdStatus(); wrData();     check("R3/R4 write clears tx only", 8'h28);
    rdData();                 check("R4 read clears rx flags", 8'h00);
  endtask

  task automatic t_txGroup();
    pulseEv(8'hC0);           check("R2 tx flags set", 8'hC0);
    rdStatus(); rdData();     check("R3 data read leaves tx flags", 8'hC0);
    wrData();                 check("R3 data write clears tx flags", 8'h00);
  endtask

  task automatic t_lateFlag();
    pulseEv(8'h04); rdStatus(); pulseEv(8'h02);
    rdData();                 check("R6 late flag survives", 8'h02);
    rdData();                 check("R10 arming used up", 8'h02);
    rdStatus(); rdData();     check("R4 late flag cleared after new read", 8'h00);
  endtask

  task automatic t_setWins();
    pulseEv(8'h01); rdStatus();
    evSet = 8'h01; dataRd = 1'b1; @(negedge clk); evSet = '0; dataRd = 1'b0;
    check("R7 set wins over clear", 8'h01);
    rdData();                 check("R10 no rearm after collision", 8'h01);
    rdStatus(); rdData();     check("R4 cleared after new read", 8'h00);
  endtask

  task automatic t_idleRearm();
    pulseEv(8'h10);           check("R2 idle set", 8'h10);
    rdStatus(); rdData();     check("R4 idle cleared", 8'h00);
    pulseEv(8'h10);           check("R8 idle ignored before activity", 8'h00);
    active(); pulseEv(8'h10); check("R8 idle set after activity", 8'h10);
    rdStatus(); rdData();     check("R4 idle cleared again", 8'h00);
  endtask

  task automatic t_wake();
    active();
    rxWake = 1'b1; pulseEv(8'h10); check("R9 idle blocked in wake-up", 8'h00);
    rxWake = 1'b0; pulseEv(8'h10); check("R9 enable kept after blocked pulse", 8'h10);
    pulseEv(8'h08);           check("R2 overrun with idle", 8'h18);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_rxGroup();
    t_txGroup();
    t_lateFlag();
    t_setWins();
    t_idleRearm();
    t_wake();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule